// File: doc/BRIEF.md
# Per-Channel Zero-Run Detector with Mute Control

This block sits in front of a multi-channel DAC datapath and watches every sample that is handed to each channel. Every channel has its own run counter. The counter advances on each sample strobe that carries a word of all zero bits. When a channel has seen 1024 such strobes in a row, its zero flag is raised. Any sample with at least one bit set clears that channel's count and its flag.

The per-channel flags feed two consumers, and each consumer has its own control bit:

- **External mute pin.** When the pin is routed to zero detection, it goes high only while every channel reports a zero run. Otherwise the pin is held low.
- **DAC mute signals.** When auto-mute is enabled, each channel's mute signal follows that channel's zero flag.

Top module: `zero_run_mute`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every run count and every zero flag is cleared. After the release of reset, a fresh run of 1024 zero strobes is needed before any flag rises.
- R2: The zero flag of a channel becomes 1 right after the edge that takes in the 1024th consecutive zero sample on that channel. After 1023 such samples it is still 0.
- R3: A strobed sample that is not zero clears the channel's run count, and its zero flag is 0 right after that same edge.
- R4: The run count stops at the threshold. The zero flag stays 1 for as long as further zero samples keep arriving, however many there are.
- R5: Edges where `smp_valid` is 0 leave every count and flag unchanged. Idle cycles inside a zero run neither break the run nor advance it.
- R6: Each channel's detector depends only on that channel's lane of `smp_data`. Lane n occupies bits [n*SAMPLE_W +: SAMPLE_W].
- R7: `mute_pin` is the AND of all zero flags when `pin_zero_route` is 1, and it is 0 when `pin_zero_route` is 0. The output is combinational from the flags and the route bit.
- R8: `ch_mute[n]` equals `zero_flag[n]` when `auto_mute_en` is 1, and it is 0 when `auto_mute_en` is 0. The output is combinational.
- R9: A sample counts as zero only if all SAMPLE_W bits are 0. A word with only the least significant bit set is not zero. A word with only the sign bit set is not zero either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample strobe for all channels |
| smp_data | input | NUM_CH*SAMPLE_W | Packed signed samples, one lane per channel |
| pin_zero_route | input | 1 | 1 routes zero detection to the mute pin |
| auto_mute_en | input | 1 | 1 lets zero flags mute their channels |
| zero_flag | output | NUM_CH | Per-channel zero-run flag |
| mute_pin | output | 1 | External mute output, 1 means zero detected |
| ch_mute | output | NUM_CH | Per-channel mute for the DAC datapath |

## Verification
The zero flags are registered, so a sample strobe shows its effect one edge later. The bench therefore applies each input just after a rising edge and reads the flags after the next rising edge. `mute_pin` and `ch_mute` add no register, so a change of either control bit is visible within the same cycle. A behavioural model with integer run counts is updated at each rising edge and compared against every output on each falling edge. Named checks are taken at the 1023rd and 1024th strobes, during long saturated runs, at idle gaps, and right after control-bit changes.

// File: rtl/zrm_pkg.sv
// Package: shared helpers for the zero-run mute block.
// Assumes: the run threshold is at least 1.
package zrm_pkg;

    // Width needed to hold a count from 0 up to and including the limit.
    function automatic int cnt_width(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/zrm_zero_test.sv
// Module: zrm_zero_test
// Purpose: tells whether a sample word is exactly zero (all bits clear).
// Assumes: sample is a plain bit vector; its sign has no special meaning.
module zrm_zero_test #(
    parameter int SAMPLE_W = 24
) (
    input  logic [SAMPLE_W-1:0] sample,
    output logic                is_zero
);

    // Reduce all bits: any set bit makes the word nonzero.
    always_comb begin
        is_zero = ~(|sample);
    end

endmodule

// File: rtl/zrm_run_counter.sv
// Module: zrm_run_counter
// Purpose: counts consecutive strobed zero samples on one channel and
//          raises a flag once the count reaches ZERO_RUN.
// Assumes: smp_valid is a single-cycle strobe; rst_n is synchronous, active low.
module zrm_run_counter
    import zrm_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int ZERO_RUN = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                zero_flag
);

    localparam int CNT_W = cnt_width(ZERO_RUN);
    localparam logic [CNT_W-1:0] LIMIT     = CNT_W'(ZERO_RUN);
    localparam logic [CNT_W-1:0] LIMIT_M1  = CNT_W'(ZERO_RUN - 1);

    logic             is_zero;
    logic [CNT_W-1:0] run_cnt;

    zrm_zero_test #(.SAMPLE_W(SAMPLE_W)) zero_test_i (
        .sample  (sample),
        .is_zero (is_zero)
    );

    // Run count and flag: advance and saturate on zero strobes, clear on nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            zero_flag <= 1'b0;
        end else if (smp_valid) begin
            if (is_zero) begin
                if (run_cnt != LIMIT) begin
                    run_cnt <= run_cnt + 1'b1;
                end
                zero_flag <= (run_cnt >= LIMIT_M1);
            end else begin
                run_cnt   <= '0;
                zero_flag <= 1'b0;
            end
        end
    end

    // R2: the flag only rises once the count has reached the threshold
    assert_rise_at_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_flag) |-> (run_cnt == LIMIT));

    // R3: a strobed nonzero sample leaves the flag low after the edge
    assert_clear_on_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (sample != '0)) |=> !zero_flag);

    // R4: the count never passes the threshold
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= LIMIT);

    // R4: a raised flag survives further zero samples
    assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_flag && smp_valid && (sample == '0)) |=> zero_flag);

    // R5: without a strobe neither flag nor count moves
    assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(zero_flag) && $stable(run_cnt)));

endmodule

// File: rtl/zrm_mute_drive.sv
// Module: zrm_mute_drive
// Purpose: turns the per-channel zero flags into the external mute pin
//          and the per-channel DAC mute signals.
// Assumes: flags are registered upstream; the outputs here are combinational.
module zrm_mute_drive #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] zero_flag,
    input  logic              pin_zero_route,
    input  logic              auto_mute_en,
    output logic              mute_pin,
    output logic [NUM_CH-1:0] ch_mute
);

    // Pin: all channels must report zero, and only when routed.
    always_comb begin
        mute_pin = pin_zero_route & (&zero_flag);
    end

    // Per-channel mute gated by the auto-mute enable.
    always_comb begin
        ch_mute = zero_flag & {NUM_CH{auto_mute_en}};
    end

    // R7: an unrouted pin stays low
    assert_pin_unrouted_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_zero_route |-> !mute_pin);

    // R7: a high pin implies every channel flags zero
    assert_pin_needs_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mute_pin |-> (&zero_flag));

    // R8: no mute without enable
    assert_mute_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_mute_en |-> (ch_mute == '0));

    // R8: a muted channel must be flagging zero
    assert_mute_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_mute & ~zero_flag) == '0);

endmodule

// File: rtl/zero_run_mute.sv
// Module: zero_run_mute (top)
// Purpose: one zero-run detector per DAC channel plus mute routing.
// Assumes: all channels share one sample strobe; lane n of smp_data is
//          bits [n*SAMPLE_W +: SAMPLE_W]; synchronous active-low reset.
module zero_run_mute #(
    parameter int NUM_CH   = 6,
    parameter int SAMPLE_W = 24,
    parameter int ZERO_RUN = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
    input  logic                       pin_zero_route,
    input  logic                       auto_mute_en,
    output logic [NUM_CH-1:0]          zero_flag,
    output logic                       mute_pin,
    output logic [NUM_CH-1:0]          ch_mute
);

    // R6: one independent detector per lane
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        zrm_run_counter #(
            .SAMPLE_W (SAMPLE_W),
            .ZERO_RUN (ZERO_RUN)
        ) run_cnt_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (smp_valid),
            .sample    (smp_data[ch*SAMPLE_W +: SAMPLE_W]),
            .zero_flag (zero_flag[ch])
        );
    end

    zrm_mute_drive #(.NUM_CH(NUM_CH)) mute_drive_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .zero_flag      (zero_flag),
        .pin_zero_route (pin_zero_route),
        .auto_mute_en   (auto_mute_en),
        .mute_pin       (mute_pin),
        .ch_mute        (ch_mute)
    );

    // R1: flags are low on the edge after reset is sampled
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (zero_flag == '0));

endmodule

// File: tb/zero_run_mute_tb.sv
// Bench: behavioural reference model compared on every falling edge,
// plus named checks at the boundary points of each requirement.
module zero_run_mute_tb_top;

    localparam int NUM_CH   = 6;
    localparam int SAMPLE_W = 24;
    localparam int ZERO_RUN = 1024;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       smp_valid = 1'b0;
    logic [NUM_CH*SAMPLE_W-1:0] smp_data;
    logic                       pin_zero_route = 1'b0;
    logic                       auto_mute_en = 1'b0;
    logic [NUM_CH-1:0]          zero_flag;
    logic                       mute_pin;
    logic [NUM_CH-1:0]          ch_mute;

    logic [SAMPLE_W-1:0] lane [NUM_CH];

    int checks = 0;
    int errors = 0;
    int run_ref [NUM_CH];
    bit flag_ref [NUM_CH];

    always #2 clk = ~clk;   // 250 MHz

    always_comb begin
        for (int ch = 0; ch < NUM_CH; ch++) smp_data[ch*SAMPLE_W +: SAMPLE_W] = lane[ch];
    end

    zero_run_mute #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .ZERO_RUN(ZERO_RUN)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .pin_zero_route(pin_zero_route), .auto_mute_en(auto_mute_en),
        .zero_flag(zero_flag), .mute_pin(mute_pin), .ch_mute(ch_mute)
    );

    // Reference model: integer run counts updated on each rising edge.
    always @(posedge clk) begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (!rst_n) begin
                run_ref[ch] = 0; flag_ref[ch] = 0;
            end else if (smp_valid) begin
                if (lane[ch] == 0) begin
                    if (run_ref[ch] < ZERO_RUN) run_ref[ch] = run_ref[ch] + 1;
                    flag_ref[ch] = (run_ref[ch] >= ZERO_RUN);
                end else begin
                    run_ref[ch] = 0; flag_ref[ch] = 0;
                end
            end
        end
    end

    function automatic logic [NUM_CH-1:0] ref_flags();
        logic [NUM_CH-1:0] f;
        for (int ch = 0; ch < NUM_CH; ch++) f[ch] = flag_ref[ch];
        return f;
    endfunction

    // Every-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        logic [NUM_CH-1:0] ef;
        logic ep;
        logic [NUM_CH-1:0] em;
        ef = ref_flags();
        ep = pin_zero_route & (&ef);
        em = auto_mute_en ? ef : '0;
        checks++;
        if (zero_flag !== ef || mute_pin !== ep || ch_mute !== em) begin
            errors++;
            $display("FAIL R2 R3 R4 R5 R6 R7 R8 per-cycle: flag=%b pin=%b mute=%b expected flag=%b pin=%b mute=%b",
                     zero_flag, mute_pin, ch_mute, ef, ep, em);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply current inputs for one rising edge; return at edge + 1 ns.
    task automatic cyc(input logic v);
        smp_valid = v;
        @(posedge clk); #1;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int ch = 0; ch < NUM_CH; ch++) lane[ch] = '0;
        @(posedge clk); #1;
        repeat (3) cyc(1'b1);             // zeros strobed during reset
        check("R1 reset flags", zero_flag, '0);
        check("R1 reset pin", mute_pin, 0);
        rst_n = 1'b1;

        // Channel 0 zero, others nonzero; idle gaps inside the run.
        for (int ch = 1; ch < NUM_CH; ch++) lane[ch] = SAMPLE_W'(ch + 1);
        for (int i = 0; i < 1023; i++) begin
            if (i % 100 == 50) begin cyc(1'b0); cyc(1'b0); end
            cyc(1'b1);
        end
        check("R2 after 1023 zeros", zero_flag[0], 0);
        check("R5 idle gaps kept run", run_ref[0], 1023);
        cyc(1'b0);
        check("R5 idle does not advance", zero_flag[0], 0);
        cyc(1'b1);
        check("R2 after 1024 zeros", zero_flag[0], 1);
        check("R6 other channels clear", zero_flag[NUM_CH-1:1], '0);

        // Saturation and auto-mute.
        strobes(1500);
        check("R4 flag held in long run", zero_flag[0], 1);
        check("R8 no mute when disabled", ch_mute, '0);
        auto_mute_en = 1'b1; #1;
        check("R8 mute follows flag", ch_mute, 32'h1);
        cyc(1'b0);
        check("R5 idle keeps flag", zero_flag[0], 1);

        // Nonzero words: LSB only, then sign bit only.
        lane[0] = SAMPLE_W'(1);
        cyc(1'b1);
        check("R3 R9 LSB clears flag", zero_flag[0], 0);
        check("R8 mute drops with flag", ch_mute[0], 0);
        lane[0] = '0;
        strobes(ZERO_RUN);
        check("R2 rerun sets flag", zero_flag[0], 1);
        lane[0] = {1'b1, {(SAMPLE_W-1){1'b0}}};
        cyc(1'b1);
        check("R3 R9 sign bit clears flag", zero_flag[0], 0);

        // All channels zero, pin routing.
        for (int ch = 0; ch < NUM_CH; ch++) lane[ch] = '0;
        strobes(ZERO_RUN);
        check("R6 all flags set", zero_flag, {NUM_CH{1'b1}});
        check("R7 pin low when unrouted", mute_pin, 0);
        pin_zero_route = 1'b1; #1;
        check("R7 pin high when routed", mute_pin, 1);
        lane[3] = SAMPLE_W'(24'h800);
        cyc(1'b1);
        check("R7 pin low with one channel active", mute_pin, 0);
        check("R6 only lane 3 cleared", zero_flag, {NUM_CH{1'b1}} & ~(NUM_CH'(1) << 3));
        auto_mute_en = 1'b0; #1;
        check("R8 mute off when disabled", ch_mute, '0);

        // Reset in the middle of a run.
        lane[3] = '0;
        strobes(500);
        rst_n = 1'b0;
        cyc(1'b1);
        check("R1 reset mid run", zero_flag, '0);
        rst_n = 1'b1;
        strobes(ZERO_RUN - 1);
        check("R1 count restarted after reset", zero_flag, '0);
        cyc(1'b1);
        check("R1 R2 flags after fresh run", zero_flag, {NUM_CH{1'b1}});
        check("R7 pin after fresh run", mute_pin, 1);

        cyc(1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule